// File: doc/BRIEF.md
# Shared-Select Host Access Decoder

This block sits behind a host slave port that several identical devices share. The port is synchronous and uses a single strobe. All devices see the same select line, address, byte enables and write data. Each device keeps only the accesses meant for it. The top bits of the host address carry a device identifier. The block compares that identifier with the value strapped on its own pins. An identifier of all ones is a broadcast code. A write with that code is taken by every device, and a read with it is taken by none.

The remaining address bits form an offset inside the device. When the window mode is off, the offset is zero-extended to form the internal address. When the window mode is on, a base register supplies the upper internal address bits, so a host with few address pins can reach a larger internal space. The host loads the base by writing to the reserved offset of all ones. Write byte enables must select an aligned group of 1, 2, 4 or 8 bytes. The write data and byte enables are rearranged to big-endian, little-endian or munged order before they are presented to the internal side. Each accepted access returns a ready pulse.

Top module: `host_slave_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `host_ready` and `int_valid` are low. The window base is zero after reset.
- R2: A strobed access whose ID field (`host_addr[20:18]`) equals `strap_id` is accepted. On the clock edge after the strobe, `host_ready` and `int_valid` rise for one cycle, with `int_write` equal to `host_wr`. Reads are accepted whatever `host_be` holds.
- R3: An access whose ID matches neither `strap_id` nor the broadcast code `3'b111` produces no `host_ready` and no `int_valid`.
- R4: A write carrying the broadcast code is accepted whatever `strap_id` holds.
- R5: A read carrying the broadcast code is ignored and gives no ready, unless `strap_id` is itself `3'b111`.
- R6: With `win_mode` low, `int_addr` is the 18-bit offset `host_addr[17:0]` zero-extended to 24 bits.
- R7: With `win_mode` high, `int_addr` is the 6-bit window base followed by the 18-bit offset.
- R8: An accepted write to offset `18'h3FFFF` loads the window base from `host_wdata[5:0]` and returns ready, but raises no `int_valid`. The new base applies from the next access onward.
- R9: A write is dropped, with no ready and no strobe, unless `host_be` is one aligned group of 1, 2, 4 or 8 set bits. An aligned group of N bits has its lowest set bit at a multiple of N.
- R10: With `byte_order` = 0 (big-endian), write data and byte enables pass through unchanged.
- R11: With `byte_order` = 1 (little-endian), byte lane i of the data and bit i of the enables move to lane 7-i.
- R12: With `byte_order` = 2 (munged), the two 32-bit halves are swapped in both data and enables, and byte order inside each half is kept. Code 3 behaves as code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Shared access strobe, one cycle per access |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | 21 | ID field [20:18] and offset [17:0] |
| host_be | input | 8 | Write byte enables, bit i for byte lane i |
| host_wdata | input | 64 | Write data from the host |
| strap_id | input | 3 | Strapped device identifier |
| win_mode | input | 1 | Enables the window base as upper address |
| byte_order | input | 2 | 0 big, 1 little, 2 munged, 3 as big |
| int_valid | output | 1 | Internal access strobe |
| int_write | output | 1 | Internal access direction |
| int_addr | output | 24 | Internal address |
| int_be | output | 8 | Reordered byte enables |
| int_wdata | output | 64 | Reordered write data |
| host_ready | output | 1 | Ready response to the host |

## Verification
Every result here lands exactly one clock edge after the strobe. The ready pulse, the internal strobe and its address, data and enables all appear there. A window load is the one exception to timing: it shows up only as a changed address on the next accepted access. The bench drives on falling edges. A reference model updates on the rising edge from the inputs that edge saw. All outputs are compared with the model on the next falling edge, so every check sits one edge after its stimulus.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  localparam int NBYTES = 8;
  localparam int DW     = NBYTES * 8;

  typedef enum logic [1:0] {
    ORD_BIG    = 2'd0,
    ORD_LITTLE = 2'd1,
    ORD_MUNGED = 2'd2,
    ORD_SPARE  = 2'd3
  } order_e;

  // true when the enables form one naturally aligned power-of-two group
  function automatic logic be_aligned(input logic [NBYTES-1:0] be);
    logic ok;
    logic [NBYTES-1:0] m;
    ok = 1'b0;
    for (int sz = 1; sz <= NBYTES; sz = sz * 2) begin
      for (int p = 0; p < NBYTES; p = p + sz) begin
        m = '0;
        for (int k = 0; k < sz; k++) m[p+k] = 1'b1;
        if (be == m) ok = 1'b1;
      end
    end
    return ok;
  endfunction

  function automatic logic [DW-1:0] rev_bytes(input logic [DW-1:0] d);
    logic [DW-1:0] r;
    for (int i = 0; i < NBYTES; i++) r[8*i +: 8] = d[8*(NBYTES-1-i) +: 8];
    return r;
  endfunction

  function automatic logic [NBYTES-1:0] rev_bits(input logic [NBYTES-1:0] b);
    logic [NBYTES-1:0] r;
    for (int i = 0; i < NBYTES; i++) r[i] = b[NBYTES-1-i];
    return r;
  endfunction
endpackage

// File: rtl/hsd_match.sv
module hsd_match #(
  parameter int ID_W = 3
) (
  input  logic            sel,
  input  logic            wr,
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] strap,
  input  logic [7:0]      be,
  output logic            own_hit,
  output logic            bcast_hit,
  output logic            accept
);
  import hsd_pkg::*;
  localparam logic [ID_W-1:0] BCAST = '1;

  logic be_ok;

  assign own_hit   = sel && (id == strap);
  assign bcast_hit = sel && wr && (id == BCAST);
  assign be_ok     = be_aligned(be);
  assign accept    = (own_hit || bcast_hit) && (!wr || be_ok);
endmodule

// File: rtl/hsd_window.sv
module hsd_window #(
  parameter int OFF_W = 18,
  parameter int WIN_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [WIN_W-1:0]       load_val,
  input  logic                   win_mode,
  input  logic [OFF_W-1:0]       offset,
  output logic [WIN_W+OFF_W-1:0] addr
);
  logic [WIN_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= load_val;
  end

  assign addr = win_mode ? {base_q, offset} : {{WIN_W{1'b0}}, offset};

  p_base_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> base_q == $past(load_val));
  p_base_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base_q));
endmodule

// File: rtl/hsd_lane.sv
module hsd_lane (
  input  logic [1:0]  order,
  input  logic [63:0] din,
  input  logic [7:0]  be_in,
  output logic [63:0] dout,
  output logic [7:0]  be_out
);
  import hsd_pkg::*;
  localparam int HALF = DW / 2;
  localparam int HB   = NBYTES / 2;

  always_comb begin
    unique case (order_e'(order))
      ORD_LITTLE: begin
        dout   = rev_bytes(din);
        be_out = rev_bits(be_in);
      end
      ORD_MUNGED: begin
        dout   = {din[HALF-1:0], din[DW-1:HALF]};
        be_out = {be_in[HB-1:0], be_in[NBYTES-1:HB]};
      end
      default: begin
        dout   = din;
        be_out = be_in;
      end
    endcase
  end
endmodule

// File: rtl/host_slave_decoder.sv
module host_slave_decoder #(
  parameter int HOST_AW = 21,
  parameter int ID_W    = 3,
  parameter int WIN_W   = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               host_sel,
  input  logic                               host_wr,
  input  logic [HOST_AW-1:0]                 host_addr,
  input  logic [7:0]                         host_be,
  input  logic [63:0]                        host_wdata,
  input  logic [ID_W-1:0]                    strap_id,
  input  logic                               win_mode,
  input  logic [1:0]                         byte_order,
  output logic                               int_valid,
  output logic                               int_write,
  output logic [WIN_W+HOST_AW-ID_W-1:0]      int_addr,
  output logic [7:0]                         int_be,
  output logic [63:0]                        int_wdata,
  output logic                               host_ready
);
  localparam int OFF_W = HOST_AW - ID_W;
  localparam int IA_W  = WIN_W + OFF_W;
  localparam logic [OFF_W-1:0] WIN_SLOT = '1;
  localparam logic [ID_W-1:0]  BCAST    = '1;

  logic [ID_W-1:0]  acc_id;
  logic [OFF_W-1:0] acc_off;
  logic             own_hit, bcast_hit, accept, win_load;
  logic [IA_W-1:0]  mapped_addr;
  logic [63:0]      lane_data;
  logic [7:0]       lane_be;

  assign acc_id  = host_addr[HOST_AW-1:OFF_W];
  assign acc_off = host_addr[OFF_W-1:0];

  hsd_match #(.ID_W(ID_W)) u_match (
    .sel(host_sel), .wr(host_wr), .id(acc_id), .strap(strap_id), .be(host_be),
    .own_hit(own_hit), .bcast_hit(bcast_hit), .accept(accept)
  );

  assign win_load = accept && host_wr && (acc_off == WIN_SLOT);

  hsd_window #(.OFF_W(OFF_W), .WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .load(win_load), .load_val(host_wdata[WIN_W-1:0]),
    .win_mode(win_mode), .offset(acc_off), .addr(mapped_addr)
  );

  hsd_lane u_lane (
    .order(byte_order), .din(host_wdata), .be_in(host_be),
    .dout(lane_data), .be_out(lane_be)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_ready <= 1'b0;
      int_valid  <= 1'b0;
      int_write  <= 1'b0;
      int_addr   <= '0;
      int_be     <= '0;
      int_wdata  <= '0;
    end else begin
      host_ready <= accept;
      int_valid  <= accept && !win_load;
      if (accept) begin
        int_write <= host_wr;
        int_addr  <= mapped_addr;
        int_be    <= lane_be;
        int_wdata <= lane_data;
      end
    end
  end

  p_accept_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && acc_id == strap_id && !host_wr) |=> (host_ready && int_valid && !int_write));
  p_foreign_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && acc_id != strap_id && acc_id != BCAST) |=> !host_ready);
  p_bcast_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_hit && accept) |=> host_ready);
  p_bcast_read_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr && acc_id == BCAST && strap_id != BCAST) |=> !host_ready);
  p_valid_has_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> host_ready);
  p_be_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && int_write) |-> ($countones(int_be) == 1 || $countones(int_be) == 2 ||
                                  $countones(int_be) == 4 || $countones(int_be) == 8));
  p_slot_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_load |=> (host_ready && !int_valid));
endmodule

// File: tb/host_slave_decoder_test.sv
module host_slave_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0, win_mode = 1'b0;
  logic [20:0] host_addr = '0;
  logic [7:0]  host_be = '0;
  logic [63:0] host_wdata = '0;
  logic [2:0]  strap_id = 3'd5;
  logic [1:0]  byte_order = 2'd0;
  logic        int_valid, int_write, host_ready;
  logic [23:0] int_addr;
  logic [7:0]  int_be;
  logic [63:0] int_wdata;

  int n_checks = 0, n_fail = 0, cycles = 0;
  string tag = "R1", m_tag = "R1";

  logic        m_ready = 0, m_valid = 0, m_write = 0;
  logic [23:0] m_addr = 0;
  logic [7:0]  m_be = 0;
  logic [63:0] m_data = 0;
  logic [5:0]  m_win = 0;

  always #10 clk = ~clk;

  host_slave_decoder uut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
    .strap_id(strap_id), .win_mode(win_mode), .byte_order(byte_order),
    .int_valid(int_valid), .int_write(int_write), .int_addr(int_addr),
    .int_be(int_be), .int_wdata(int_wdata), .host_ready(host_ready)
  );

  function automatic bit legal_be(input logic [7:0] be);
    int n = 0, lo = -1;
    for (int i = 7; i >= 0; i--) if (be[i]) begin n++; lo = i; end
    if (!(n == 1 || n == 2 || n == 4 || n == 8)) return 0;
    if (lo % n != 0) return 0;
    return be == 8'(((1 << n) - 1) << lo);
  endfunction

  // reference model: state updated on the rising edge from the sampled inputs
  always @(posedge clk) begin
    logic [2:0]  id;
    logic [17:0] off;
    bit hit, acc, ld;
    logic [63:0] d;
    logic [7:0]  b;
    id  = host_addr[20:18];
    off = host_addr[17:0];
    m_tag <= tag;
    if (!rst_n) begin
      m_ready <= 0; m_valid <= 0; m_win <= 0;
    end else begin
      hit = host_sel && (id == strap_id || (id == 3'b111 && host_wr));
      acc = hit && (!host_wr || legal_be(host_be));
      ld  = acc && host_wr && off == 18'h3FFFF;
      m_ready <= acc;
      m_valid <= acc && !ld;
      if (ld) m_win <= host_wdata[5:0];
      if (acc) begin
        m_write <= host_wr;
        m_addr  <= win_mode ? {m_win, off} : {6'd0, off};
        d = host_wdata; b = host_be;
        if (byte_order == 2'd1) begin
          for (int i = 0; i < 8; i++) begin
            d[8*i +: 8] = host_wdata[8*(7-i) +: 8];
            b[i] = host_be[7-i];
          end
        end else if (byte_order == 2'd2) begin
          d = {host_wdata[31:0], host_wdata[63:32]};
          b = {host_be[3:0], host_be[7:4]};
        end
        m_data <= d; m_be <= b;
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", m_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk("host_ready", 64'(host_ready), 64'(m_ready));
    chk("int_valid", 64'(int_valid), 64'(m_valid));
    if (m_valid) begin
      chk("int_write", 64'(int_write), 64'(m_write));
      chk("int_addr", 64'(int_addr), 64'(m_addr));
      chk("int_wdata", int_wdata, m_data);
      if (m_write) chk("int_be", 64'(int_be), 64'(m_be));
    end
    if (cycles > 5000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic acc(input string t, input bit wr, input logic [2:0] id,
                     input logic [17:0] off, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk);
    tag = t; host_sel = 1; host_wr = wr; host_addr = {id, off}; host_be = be; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    acc("R2", 1, 3'd5, 18'h00123, 8'hFF, 64'h1111_2222_3333_4444);
    acc("R2", 0, 3'd5, 18'h00456, 8'h06, 64'h0);
    acc("R3", 1, 3'd2, 18'h00010, 8'hFF, 64'hDEAD);
    acc("R3", 0, 3'd3, 18'h00020, 8'h00, 64'h0);
    acc("R4", 1, 3'd7, 18'h00030, 8'h0F, 64'hABCD_0000_1234);
    acc("R5", 0, 3'd7, 18'h00040, 8'h00, 64'h0);
    acc("R6", 1, 3'd5, 18'h2ABCD, 8'hFF, 64'h77);
    win_mode = 1;
    acc("R7", 0, 3'd5, 18'h01000, 8'h00, 64'h0);
    acc("R8", 1, 3'd5, 18'h3FFFF, 8'hFF, 64'h2A);
    acc("R7", 1, 3'd5, 18'h01234, 8'h30, 64'h99);
    acc("R8", 1, 3'd7, 18'h3FFFF, 8'h01, 64'h15);
    acc("R7", 0, 3'd5, 18'h00008, 8'h00, 64'h0);
    win_mode = 0;
    acc("R9", 1, 3'd5, 18'h00100, 8'h06, 64'h5);
    acc("R9", 1, 3'd5, 18'h00100, 8'h38, 64'h5);
    acc("R9", 1, 3'd5, 18'h00100, 8'h0C, 64'h5);
    acc("R9", 1, 3'd5, 18'h00100, 8'hF0, 64'h5);
    acc("R9", 1, 3'd5, 18'h00100, 8'h00, 64'h5);
    byte_order = 2'd0;
    acc("R10", 1, 3'd5, 18'h00200, 8'h03, 64'h0102_0304_0506_0708);
    byte_order = 2'd1;
    acc("R11", 1, 3'd5, 18'h00200, 8'h03, 64'h0102_0304_0506_0708);
    acc("R11", 1, 3'd5, 18'h00200, 8'h30, 64'h1122_3344_5566_7788);
    byte_order = 2'd2;
    acc("R12", 1, 3'd5, 18'h00200, 8'h03, 64'h0102_0304_0506_0708);
    acc("R12", 1, 3'd5, 18'h00200, 8'hF0, 64'hA1A2_A3A4_B1B2_B3B4);
    byte_order = 2'd3;
    acc("R12", 1, 3'd5, 18'h00200, 8'h0C, 64'h0102_0304_0506_0708);
    strap_id = 3'd7;
    byte_order = 2'd0;
    acc("R5", 0, 3'd7, 18'h00044, 8'h00, 64'h0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule